// File: doc/BRIEF.md
# Dual-Style Host Bus Slave

This block lets an external 8-bit processor reach two independent internal register spaces over a non-multiplexed bus with a 10-bit address. A two-bit style input sets how the strobes are read. In the first style there is a separate active-low read strobe and a separate active-low write strobe. In the second style a read/write direction level is paired with one active-low data strobe. Each of the two active-low chip selects steers an access to its own register space. The bidirectional data bus is modelled as an input, an output and an output enable. The output enable is high only while a valid read is in progress.

Writes move into the block clock domain through a synchroniser chain. Each write is committed exactly once, on the deasserting edge of the write qualification. The surrounding logic receives it as a one-cycle write pulse for the addressed space, together with the captured address and data. Reads are combinational from the pins. Read data comes from the selected space's read-data input.

The block also holds the interrupt logic. A vector of interrupt sources is latched into sticky status bits, and software clears a bit by writing 1 to it. A mask register selects which status bits may pull the open-drain interrupt line low. That line is modelled as an enable that drives low. The mask and the status sit at the top two addresses of space 0.

Top module: `hbus_dual_slave`

## Requirements
- R1: With the style input at 00, an access with sel0_n or sel1_n low and wr_n low is a write. It produces exactly one write pulse, after wr_n rises, carrying the address and data present while wr_n was low.
- R2: With the style input at 00, rd_n low with one chip select low raises data_oe. data_out then shows reg_rdata0 for sel0_n or reg_rdata1 for sel1_n. data_oe falls when rd_n rises.
- R3: With the style input at 01, ds_n low with rnw low is a write. It is committed once after ds_n rises, with the address and data held during the strobe.
- R4: With the style input at 01, ds_n low with rnw high is a read. It drives data_out from the selected space while ds_n stays low.
- R5: A write through sel0_n pulses only reg_we0, and a write through sel1_n pulses only reg_we1. With both chip selects low, or both high, there is no write pulse and data_oe stays low.
- R6: Style values 10 and 11 are reserved. Under them no strobe produces a write pulse or raises data_oe.
- R7: In style 00 the ds_n and rnw pins have no effect, and in style 01 the rd_n and wr_n pins have no effect. In both cases there is neither a write pulse nor a raised data_oe.
- R8: A write strobe held low for many cycles produces no pulse while it is held. It produces one pulse lasting one clock after release.
- R9: Any irq_src bit seen high at a clock edge sets the matching status bit, and the bit stays set after the source falls. Status reads at space 0 address 0x3FF, with bit i for source i.
- R10: Writing the status address clears each status bit written as 1 and leaves the bits written as 0 unchanged. An active source wins over a clear in the same cycle. The mask reads and writes at space 0 address 0x3FE.
- R11: After reset, mask and status are zero and irq_oe is low. irq_oe is high exactly when some status bit has its mask bit set.
- R12: Writes to the mask or status address do not pulse reg_we0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_style | input | 2 | 00 separate strobes, 01 direction plus data strobe, others reserved |
| addr | input | 10 | Host address |
| data_in | input | 8 | Host write data (bus input side) |
| data_out | output | 8 | Read data (bus output side) |
| data_oe | output | 1 | Drive enable for the data bus |
| sel0_n | input | 1 | Chip select for space 0, active low |
| sel1_n | input | 1 | Chip select for space 1, active low |
| rd_n | input | 1 | Read strobe, style 00 |
| wr_n | input | 1 | Write strobe, style 00 |
| rnw | input | 1 | Direction level, style 01 (1 = read) |
| ds_n | input | 1 | Data strobe, style 01 |
| reg_we0 | output | 1 | One-cycle write pulse into space 0 |
| reg_we1 | output | 1 | One-cycle write pulse into space 1 |
| reg_waddr | output | 10 | Captured write address |
| reg_wdata | output | 8 | Captured write data |
| reg_rdata0 | input | 8 | Read data from space 0 for the current address |
| reg_rdata1 | input | 8 | Read data from space 1 for the current address |
| irq_src | input | 8 | Interrupt source conditions |
| irq_oe | output | 1 | Drives the open-drain interrupt line low when high |

## Verification
The bench tries the strobe pins of the wrong style under each mode. A decoder that ignored the style input would then raise data_oe or issue writes. It asserts both chip selects together, where a priority decoder would wrongly pick one space. It holds a write strobe low for many cycles, which exposes a design that writes on the leading edge or on every level-high cycle. It also clears status while the source is still active, and it writes the interrupt addresses. A design that gave the clear priority, or that forwarded those writes into space 0, would be caught there.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

   typedef enum logic [1:0] {
      STYLE_SPLIT = 2'b00,
      STYLE_DSTRB = 2'b01,
      STYLE_RSV2  = 2'b10,
      STYLE_RSV3  = 2'b11
   } bus_style_e;

   // read qualification from raw pins for the chosen style
   function automatic logic style_rd(bus_style_e s, logic rd_n, logic rnw, logic ds_n);
      case (s)
         STYLE_SPLIT: style_rd = ~rd_n;
         STYLE_DSTRB: style_rd = ~ds_n & rnw;
         default:     style_rd = 1'b0;
      endcase
   endfunction

   // write qualification from raw pins for the chosen style
   function automatic logic style_wr(bus_style_e s, logic wr_n, logic rnw, logic ds_n);
      case (s)
         STYLE_SPLIT: style_wr = ~wr_n;
         STYLE_DSTRB: style_wr = ~ds_n & ~rnw;
         default:     style_wr = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("hbus_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("hbus_sync: W must be positive");
   end

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) begin
            chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/hbus_irq.sv
module hbus_irq #(
   parameter int N_SRC = 8,
   parameter int DW    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src,
   input  logic             mask_we,
   input  logic             clr_we,
   input  logic [DW-1:0]    wdata,
   output logic [N_SRC-1:0] mask,
   output logic [N_SRC-1:0] status,
   output logic             irq_oe
);

   if (N_SRC > DW || N_SRC < 1) begin : g_bad_nsrc
      $error("hbus_irq: N_SRC must be 1..DW");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask <= '0;
      else if (mask_we) mask <= wdata[N_SRC-1:0];
   end

   for (genvar i = 0; i < N_SRC; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     status[i] <= 1'b0;
         else if (src[i])                status[i] <= 1'b1;
         else if (clr_we && wdata[i])    status[i] <= 1'b0;
      end

      // R9
      sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         src[i] |=> status[i]);

      // R10
      w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_we && wdata[i] && !src[i]) |=> !status[i]);
   end

   assign irq_oe = |(status & mask);

endmodule

// File: rtl/hbus_dual_slave.sv
module hbus_dual_slave
   import hbus_pkg::*;
#(
   parameter int AW          = 10,
   parameter int DW          = 8,
   parameter int N_IRQ       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int MASK_OFS    = 1022,
   parameter int STAT_OFS    = 1023
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       bus_style,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    data_in,
   output logic [DW-1:0]    data_out,
   output logic             data_oe,
   input  logic             sel0_n,
   input  logic             sel1_n,
   input  logic             rd_n,
   input  logic             wr_n,
   input  logic             rnw,
   input  logic             ds_n,
   output logic             reg_we0,
   output logic             reg_we1,
   output logic [AW-1:0]    reg_waddr,
   output logic [DW-1:0]    reg_wdata,
   input  logic [DW-1:0]    reg_rdata0,
   input  logic [DW-1:0]    reg_rdata1,
   input  logic [N_IRQ-1:0] irq_src,
   output logic             irq_oe
);

   localparam int            SW     = 2 + AW + DW;
   localparam logic [AW-1:0] MASK_A = AW'(MASK_OFS);
   localparam logic [AW-1:0] STAT_A = AW'(STAT_OFS);

   if (MASK_OFS == STAT_OFS) begin : g_bad_ofs
      $error("hbus_dual_slave: mask and status offsets collide");
   end
   if (MASK_OFS >= (1 << AW) || STAT_OFS >= (1 << AW)) begin : g_bad_range
      $error("hbus_dual_slave: interrupt offsets outside address space");
   end

   // ---------------- raw pin qualification ----------------
   bus_style_e style;
   logic       sel0, sel1, one_sel, rd_q, wr_q;

   assign style   = bus_style_e'(bus_style);
   assign sel0    = ~sel0_n;
   assign sel1    = ~sel1_n;
   assign one_sel = sel0 ^ sel1;
   assign rd_q    = one_sel & style_rd(style, rd_n, rnw, ds_n);
   assign wr_q    = one_sel & style_wr(style, wr_n, rnw, ds_n);

   // ---------------- read path (combinational) ----------------
   logic [N_IRQ-1:0] irq_mask, irq_stat;

   always_comb begin
      if (sel1)                data_out = reg_rdata1;
      else if (addr == MASK_A) data_out = DW'(irq_mask);
      else if (addr == STAT_A) data_out = DW'(irq_stat);
      else                     data_out = reg_rdata0;
   end
   assign data_oe = rd_q;

   // ---------------- write path: synchronise, capture, commit ----------------
   logic [SW-1:0] s_bus;
   logic          s_act, s_sp;
   logic [AW-1:0] s_addr;
   logic [DW-1:0] s_data;

   hbus_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({wr_q, sel1, addr, data_in}),
      .q     (s_bus)
   );
   assign {s_act, s_sp, s_addr, s_data} = s_bus;

   logic          act_q, cap_sp;
   logic [AW-1:0] cap_addr;
   logic [DW-1:0] cap_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q    <= 1'b0;
         cap_sp   <= 1'b0;
         cap_addr <= '0;
         cap_data <= '0;
      end else begin
         act_q <= s_act;
         if (s_act) begin
            cap_sp   <= s_sp;
            cap_addr <= s_addr;
            cap_data <= s_data;
         end
      end
   end

   logic commit, hit_mask, hit_stat;
   assign commit   = act_q & ~s_act;
   assign hit_mask = cap_addr == MASK_A;
   assign hit_stat = cap_addr == STAT_A;

   assign reg_we0   = commit & ~cap_sp & ~(hit_mask | hit_stat);
   assign reg_we1   = commit & cap_sp;
   assign reg_waddr = cap_addr;
   assign reg_wdata = cap_data;

   // ---------------- interrupt collection ----------------
   hbus_irq #(.N_SRC(N_IRQ), .DW(DW)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     (irq_src),
      .mask_we (commit & ~cap_sp & hit_mask),
      .clr_we  (commit & ~cap_sp & hit_stat),
      .wdata   (cap_data),
      .mask    (irq_mask),
      .status  (irq_stat),
      .irq_oe  (irq_oe)
   );

   // R5
   one_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we0 && reg_we1));

   // R8
   single_pulse0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we0 |=> !reg_we0);

   // R8
   single_pulse1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we1 |=> !reg_we1);

   // R6
   rsv_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe |-> !bus_style[1]);

endmodule

// File: tb/tb_hbus_dual_slave.sv
module tb_hbus_dual_slave;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_style = 2'b00;
   logic [9:0] addr = '0;
   logic [7:0] data_in = '0;
   logic [7:0] data_out;
   logic       data_oe;
   logic       sel0_n = 1'b1, sel1_n = 1'b1;
   logic       rd_n = 1'b1, wr_n = 1'b1, rnw = 1'b1, ds_n = 1'b1;
   logic       reg_we0, reg_we1;
   logic [9:0] reg_waddr;
   logic [7:0] reg_wdata;
   logic [7:0] reg_rdata0, reg_rdata1;
   logic [7:0] irq_src = '0;
   logic       irq_oe;

   always #10 clk = ~clk;

   // register-space models: read data is a function of the host address
   assign reg_rdata0 = addr[7:0] ^ 8'h5A;
   assign reg_rdata1 = addr[7:0] ^ 8'hC3;

   hbus_dual_slave dut (
      .clk(clk), .rst_n(rst_n), .bus_style(bus_style), .addr(addr),
      .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
      .sel0_n(sel0_n), .sel1_n(sel1_n), .rd_n(rd_n), .wr_n(wr_n),
      .rnw(rnw), .ds_n(ds_n), .reg_we0(reg_we0), .reg_we1(reg_we1),
      .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
      .reg_rdata0(reg_rdata0), .reg_rdata1(reg_rdata1),
      .irq_src(irq_src), .irq_oe(irq_oe)
   );

   int applied = 0, bad = 0;
   int n0 = 0, n1 = 0;
   logic [9:0] la;
   logic [7:0] ld;
   bit done = 0;

   always @(negedge clk) begin
      if (reg_we0) begin n0++; la = reg_waddr; ld = reg_wdata; end
      if (reg_we1) begin n1++; la = reg_waddr; ld = reg_wdata; end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      applied++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle_pins();
      rd_n = 1; wr_n = 1; ds_n = 1; rnw = 1;
   endtask

   task automatic host_write(input logic [1:0] st, input bit moto, input bit s0n, input bit s1n,
                             input logic [9:0] a, input logic [7:0] d, input int hold);
      @(negedge clk);
      bus_style = st; addr = a; data_in = d; sel0_n = s0n; sel1_n = s1n;
      if (moto) begin rnw = 0; ds_n = 0; end else wr_n = 0;
      repeat (hold) @(negedge clk);
      idle_pins();
      repeat (2) @(negedge clk);
      sel0_n = 1; sel1_n = 1;
      repeat (5) @(negedge clk);
   endtask

   task automatic host_read(input logic [1:0] st, input bit moto, input bit s0n, input bit s1n,
                            input logic [9:0] a, output bit oe, output logic [7:0] d, output bit oe_after);
      @(negedge clk);
      bus_style = st; addr = a; sel0_n = s0n; sel1_n = s1n;
      if (moto) begin rnw = 1; ds_n = 0; end else rd_n = 0;
      #3; oe = data_oe; d = data_out;
      @(negedge clk);
      idle_pins();
      #3; oe_after = data_oe;
      sel0_n = 1; sel1_n = 1;
   endtask

   typedef struct packed {
      logic [1:0] st;
      logic       moto;
      logic       s0n;
      logic       s1n;
      logic       rd;
      logic [9:0] a;
      logic [7:0] d;
      logic [1:0] exp;   // 0 no access, 1 space 0, 2 space 1
      logic [3:0] req;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VT [NV] = '{
      '{2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 10'h012, 8'hA5, 2'd1, 4'd1},  // R1 space 0 write
      '{2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 10'h2C4, 8'h3C, 2'd2, 4'd1},  // R1 space 1 write
      '{2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 10'h155, 8'h00, 2'd1, 4'd2},  // R2 read space 0
      '{2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 10'h0AA, 8'h00, 2'd2, 4'd2},  // R2 read space 1
      '{2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 10'h301, 8'h7E, 2'd1, 4'd3},  // R3 space 0 write
      '{2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 10'h020, 8'hC1, 2'd2, 4'd3},  // R3 space 1 write
      '{2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 10'h1F0, 8'h00, 2'd2, 4'd4},  // R4 read space 1
      '{2'b01, 1'b1, 1'b0, 1'b1, 1'b1, 10'h003, 8'h00, 2'd1, 4'd4},  // R4 read space 0
      '{2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 10'h010, 8'h11, 2'd0, 4'd5},  // R5 both selects write
      '{2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 10'h044, 8'h00, 2'd0, 4'd5},  // R5 both selects read
      '{2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 10'h045, 8'h22, 2'd0, 4'd5},  // R5 no select
      '{2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 10'h046, 8'h33, 2'd0, 4'd6},  // R6 reserved 10 write
      '{2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 10'h047, 8'h00, 2'd0, 4'd6},  // R6 reserved 11 read
      '{2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 10'h048, 8'h44, 2'd0, 4'd7},  // R7 wrong-style write
      '{2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 10'h049, 8'h00, 2'd0, 4'd7}   // R7 wrong-style read
   };

   function automatic logic [7:0] model_rd(input logic [1:0] sp, input logic [9:0] a);
      return (sp == 2'd2) ? (a[7:0] ^ 8'hC3) : (a[7:0] ^ 8'h5A);
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
         $finish;
      end
   endtask

   initial begin
      #(20 * 200000);
      applied++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      bit oe, oe2;
      logic [7:0] rd;
      int b0, b1;

      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R11 reset state
      chk(!irq_oe, "R11 irq_oe after reset", irq_oe, 0);
      chk(!data_oe && !reg_we0 && !reg_we1, "R11 idle outputs after reset",
          {data_oe, reg_we0, reg_we1}, 0);
      host_read(2'b00, 0, 0, 1, 10'h3FE, oe, rd, oe2);
      chk(oe && rd == 8'h00, "R11 mask resets to zero", rd, 0);
      host_read(2'b00, 0, 0, 1, 10'h3FF, oe, rd, oe2);
      chk(oe && rd == 8'h00, "R11 status resets to zero", rd, 0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d vec%0d", VT[i].req, i);
         if (VT[i].rd) begin
            host_read(VT[i].st, VT[i].moto, VT[i].s0n, VT[i].s1n, VT[i].a, oe, rd, oe2);
            if (VT[i].exp == 2'd0) begin
               chk(!oe, tag, oe, 0);
            end else begin
               chk(oe && rd == model_rd(VT[i].exp, VT[i].a), tag, rd, model_rd(VT[i].exp, VT[i].a));
               chk(!oe2, {tag, " release"}, oe2, 0);
            end
         end else begin
            b0 = n0; b1 = n1;
            host_write(VT[i].st, VT[i].moto, VT[i].s0n, VT[i].s1n, VT[i].a, VT[i].d, 2);
            chk((n0 - b0) == (VT[i].exp == 2'd1 ? 1 : 0) && (n1 - b1) == (VT[i].exp == 2'd2 ? 1 : 0),
                tag, (n0 - b0) * 16 + (n1 - b1),
                (VT[i].exp == 2'd1 ? 16 : 0) + (VT[i].exp == 2'd2 ? 1 : 0));
            if (VT[i].exp != 2'd0)
               chk(la == VT[i].a && ld == VT[i].d, {tag, " addr/data"}, {la, ld}, {VT[i].a, VT[i].d});
         end
      end

      // R8 long hold: nothing during the strobe, one pulse after
      @(negedge clk);
      b0 = n0;
      bus_style = 2'b00; addr = 10'h0F0; data_in = 8'h96; sel0_n = 0; wr_n = 0;
      repeat (10) @(negedge clk);
      chk(n0 == b0, "R8 no pulse while strobe held", n0 - b0, 0);
      wr_n = 1;
      repeat (2) @(negedge clk);
      sel0_n = 1;
      repeat (6) @(negedge clk);
      chk(n0 - b0 == 1 && ld == 8'h96, "R8 single pulse after release", n0 - b0, 1);

      // R9 one-cycle source pulse is latched
      @(negedge clk);
      irq_src = 8'h08;
      @(negedge clk);
      irq_src = 8'h00;
      repeat (2) @(negedge clk);
      host_read(2'b00, 0, 0, 1, 10'h3FF, oe, rd, oe2);
      chk(rd == 8'h08, "R9 status latched", rd, 8'h08);
      chk(!irq_oe, "R11 masked source keeps irq_oe low", irq_oe, 0);

      // R10/R12 mask write, not forwarded
      b0 = n0;
      host_write(2'b01, 1, 0, 1, 10'h3FE, 8'h08, 2);
      chk(n0 == b0, "R12 mask write not forwarded", n0 - b0, 0);
      chk(irq_oe, "R11 unmasked status drives irq", irq_oe, 1);
      host_read(2'b01, 1, 0, 1, 10'h3FE, oe, rd, oe2);
      chk(rd == 8'h08, "R10 mask readback", rd, 8'h08);

      // R10 writing 0 leaves the bit, writing 1 clears it
      host_write(2'b00, 0, 0, 1, 10'h3FF, 8'h00, 2);
      host_read(2'b00, 0, 0, 1, 10'h3FF, oe, rd, oe2);
      chk(rd == 8'h08, "R10 zero write keeps status", rd, 8'h08);
      b0 = n0;
      host_write(2'b00, 0, 0, 1, 10'h3FF, 8'h08, 2);
      chk(n0 == b0, "R12 status write not forwarded", n0 - b0, 0);
      host_read(2'b00, 0, 0, 1, 10'h3FF, oe, rd, oe2);
      chk(rd == 8'h00, "R10 one write clears status", rd, 0);
      chk(!irq_oe, "R11 irq released after clear", irq_oe, 0);

      // R10 active source wins over clear
      @(negedge clk);
      irq_src = 8'h02;
      host_write(2'b00, 0, 0, 1, 10'h3FF, 8'h02, 2);
      host_read(2'b00, 0, 0, 1, 10'h3FF, oe, rd, oe2);
      chk(rd == 8'h02, "R10 set wins over clear", rd, 8'h02);
      @(negedge clk);
      irq_src = 8'h00;

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule